// File: doc/BRIEF.md
# Information Flow Tag Coprocessor

This block tracks where sensitive data travels. Every word of a 256-word data space and every one of sixteen processor registers carries a one-bit tag, public (0) or secret (1). Software marks a region by issuing a range-initialization command with a base address, a word count and a tag value. A stream of already-decoded instructions then moves tags between registers and memory words without software help. Before data leaves the system, software issues a range-check command. The block reports a sticky violation when any word in that range is secret, so that the host can raise an exception.

Ranges are walked one word per cycle. While a range initialization runs, the instruction stream is held off through valid/ready backpressure. The initialization and check engines never run at the same time. Addresses in a range wrap from the top of the data space back to word 0.

Top module: `flowtag_unit`

## Requirements
- R1: After reset every memory and register tag is public, `init_busy`, `chk_done` and `chk_viol` are low, and `prop_ready` is high.
- R2: An accepted initialization (`init_valid` and `init_ready` high at a clock edge) writes `init_tag` to words `init_base` .. `init_base+init_len-1`, one word per cycle. `init_busy` is high for exactly `init_len` cycles after acceptance. A length of 0 changes no tag and never raises `init_busy`.
- R3: `prop_ready` is low whenever `init_busy` or `init_valid` is high, so an instruction presented together with, or during, an initialization only takes effect after the initialization completes.
- R4: Operation code 0 (two-source ALU) sets the tag of register `prop_rd` to the OR of the tags of `prop_rs1` and `prop_rs2`.
- R5: Operation code 1 (register move) copies the tag of `prop_rs1` to `prop_rd`.
- R6: Operation code 2 (immediate constant) makes the tag of `prop_rd` public.
- R7: Operation code 3 (load) copies the tag of memory word `prop_addr` to `prop_rd`.
- R8: Operation code 4 (store) copies the tag of `prop_rs1` to memory word `prop_addr`. No register tag changes.
- R9: An accepted check of `chk_len` words from `chk_base` pulses `chk_done` for one cycle, `chk_len+1` cycles after acceptance. A length of 0 pulses `chk_done` one cycle after acceptance and finds no violation.
- R10: `chk_viol` is set when a checked word is secret. It stays set through later checks until `viol_ack` is asserted, which clears it.
- R11: Initialization and check ranges wrap modulo 256, so the word after 255 is word 0.
- R12: `init_ready` and `chk_ready` are low while either engine is busy. When both requests arrive together on an idle block, the initialization is accepted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid | input | 1 | Range initialization request |
| init_ready | output | 1 | Initialization request can be accepted |
| init_base | input | 8 | First word of the region to tag |
| init_len | input | 9 | Number of words to tag (0..256) |
| init_tag | input | 1 | Tag value to write (1 = secret) |
| init_busy | output | 1 | Initialization walk in progress |
| prop_valid | input | 1 | Decoded instruction present |
| prop_ready | output | 1 | Instruction can be accepted |
| prop_op | input | 3 | Operation: 0 ALU, 1 move, 2 immediate, 3 load, 4 store |
| prop_rd | input | 4 | Destination register |
| prop_rs1 | input | 4 | First source register (data source of a store) |
| prop_rs2 | input | 4 | Second source register |
| prop_addr | input | 8 | Memory word address of a load or store |
| chk_valid | input | 1 | Range check request |
| chk_ready | output | 1 | Check request can be accepted |
| chk_base | input | 8 | First word of the outgoing range |
| chk_len | input | 9 | Number of words to check (0..256) |
| chk_done | output | 1 | One-cycle pulse at the end of a check |
| chk_viol | output | 1 | Sticky violation flag |
| viol_ack | input | 1 | Clears the violation flag |

## Verification
The collision that matters most is an initialization request and a decoded instruction that arrive in the same cycle. The bench raises both together. The instruction is a load from a word inside the region being marked secret. The bench confirms that `prop_ready` is already low in that cycle and that the load is taken only after the walk ends. It then judges the result by storing the loaded register to a spare word and checking that word: the load must have seen the secret tag. A second collision presents a range check in the same cycle as an initialization of the same region. The check must wait and then report the violation.

// File: rtl/flowtag_pkg.sv
package flowtag_pkg;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LEN_W  = ADDR_W + 1;
    localparam int NREG   = 16;
    localparam int REG_W  = $clog2(NREG);

    typedef enum logic [2:0] {
        OP_ALU2  = 3'd0,
        OP_MOVE  = 3'd1,
        OP_IMM   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } prop_op_e;

    typedef struct packed {
        prop_op_e          op;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rs1;
        logic [REG_W-1:0]  rs2;
        logic [ADDR_W-1:0] addr;
    } prop_req_t;

    // Destination tag for a register-writing operation; secret dominates.
    function automatic logic dest_tag(prop_op_e op, logic a, logic b, logic m);
        case (op)
            OP_ALU2: return a | b;
            OP_MOVE: return a;
            OP_LOAD: return m;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic writes_reg(prop_op_e op);
        return (op == OP_ALU2) || (op == OP_MOVE) || (op == OP_IMM) || (op == OP_LOAD);
    endfunction
endpackage

// File: rtl/flowtag_walker.sv
module flowtag_walker #(
    parameter int AW = 8,
    parameter int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    output logic          busy,
    output logic [AW-1:0] addr
);
    logic [LW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            addr   <= '0;
            remain <= '0;
        end else if (!busy) begin
            addr   <= base;
            remain <= len;
            if (start && len != '0) busy <= 1'b1;
        end else begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
            if (remain == LW'(1)) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/flowtag_regs.sv
module flowtag_regs
    import flowtag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  prop_req_t req,
    input  logic      mem_tag,
    output logic      src_tag
);
    logic [NREG-1:0] rtag;
    logic            new_tag;
    logic            wr;

    always_comb begin
        new_tag = dest_tag(req.op, rtag[req.rs1], rtag[req.rs2], mem_tag);
        wr      = fire && writes_reg(req.op);
        src_tag = rtag[req.rs1];
    end

    always_ff @(posedge clk) begin
        if (rst) rtag <= '0;
        else if (wr) rtag[req.rd] <= new_tag;
    end
endmodule

// File: rtl/flowtag_unit.sv
module flowtag_unit
    import flowtag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_valid,
    output logic              init_ready,
    input  logic [ADDR_W-1:0] init_base,
    input  logic [LEN_W-1:0]  init_len,
    input  logic              init_tag,
    output logic              init_busy,
    input  logic              prop_valid,
    output logic              prop_ready,
    input  logic [2:0]        prop_op,
    input  logic [REG_W-1:0]  prop_rd,
    input  logic [REG_W-1:0]  prop_rs1,
    input  logic [REG_W-1:0]  prop_rs2,
    input  logic [ADDR_W-1:0] prop_addr,
    input  logic              chk_valid,
    output logic              chk_ready,
    input  logic [ADDR_W-1:0] chk_base,
    input  logic [LEN_W-1:0]  chk_len,
    output logic              chk_done,
    output logic              chk_viol,
    input  logic              viol_ack
);
    logic [DEPTH-1:0]  mem;
    logic              chk_busy, chk_busy_d, chk_empty;
    logic [ADDR_W-1:0] init_addr, chk_addr;
    logic              init_go, chk_go, prop_fire;
    logic              init_tag_q, src_tag, init_we, store_we, hit;
    prop_req_t         req;

    always_comb begin
        init_ready = !init_busy && !chk_busy;
        chk_ready  = !init_busy && !chk_busy && !init_valid;
        prop_ready = !init_busy && !init_valid;
        init_go    = init_valid && init_ready;
        chk_go     = chk_valid && chk_ready;
        prop_fire  = prop_valid && prop_ready;
        req.op     = prop_op_e'(prop_op);
        req.rd     = prop_rd;
        req.rs1    = prop_rs1;
        req.rs2    = prop_rs2;
        req.addr   = prop_addr;
        init_we    = init_busy;
        store_we   = prop_fire && (req.op == OP_STORE);
        hit        = chk_busy && mem[chk_addr];
        chk_done   = (chk_busy_d && !chk_busy) || chk_empty;
    end

    flowtag_walker #(.AW(ADDR_W), .LW(LEN_W)) u_init_walk (
        .clk(clk), .rst(rst), .start(init_go), .base(init_base), .len(init_len),
        .busy(init_busy), .addr(init_addr)
    );

    flowtag_walker #(.AW(ADDR_W), .LW(LEN_W)) u_chk_walk (
        .clk(clk), .rst(rst), .start(chk_go), .base(chk_base), .len(chk_len),
        .busy(chk_busy), .addr(chk_addr)
    );

    flowtag_regs u_regs (
        .clk(clk), .rst(rst), .fire(prop_fire), .req(req),
        .mem_tag(mem[prop_addr]), .src_tag(src_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem        <= '0;
            init_tag_q <= 1'b0;
            chk_busy_d <= 1'b0;
            chk_empty  <= 1'b0;
            chk_viol   <= 1'b0;
        end else begin
            if (init_go) init_tag_q <= init_tag;
            if (init_we)       mem[init_addr] <= init_tag_q;
            else if (store_we) mem[prop_addr] <= src_tag;
            chk_busy_d <= chk_busy;
            chk_empty  <= chk_go && (chk_len == '0);
            if (hit)           chk_viol <= 1'b1;
            else if (viol_ack) chk_viol <= 1'b0;
        end
    end
endmodule

// File: rtl/flowtag_checker.sv
module flowtag_checker (
    input logic clk,
    input logic rst,
    input logic init_busy,
    input logic prop_ready,
    input logic chk_busy,
    input logic chk_done,
    input logic chk_viol,
    input logic viol_ack,
    input logic init_we,
    input logic store_we
);
    p_init_stall_r3: assert property (@(posedge clk) disable iff (rst)
        init_busy |-> !prop_ready);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> !chk_busy);

    p_viol_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (chk_viol && !viol_ack) |=> chk_viol);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (viol_ack && !chk_busy) |=> !chk_viol);

    p_engines_apart_r12: assert property (@(posedge clk) disable iff (rst)
        !(init_busy && chk_busy));

    p_one_writer_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({init_we, store_we}));
endmodule

bind flowtag_unit flowtag_checker i_flowtag_checker (
    .clk(clk), .rst(rst), .init_busy(init_busy), .prop_ready(prop_ready),
    .chk_busy(chk_busy), .chk_done(chk_done), .chk_viol(chk_viol),
    .viol_ack(viol_ack), .init_we(init_we), .store_we(store_we)
);

// File: tb/test_flowtag_unit.sv
module test_flowtag_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst = 1;
    logic       init_valid = 0, init_tag = 0;
    logic [7:0] init_base = 0;
    logic [8:0] init_len = 0;
    logic       init_ready, init_busy;
    logic       prop_valid = 0;
    logic [2:0] prop_op = 0;
    logic [3:0] prop_rd = 0, prop_rs1 = 0, prop_rs2 = 0;
    logic [7:0] prop_addr = 0;
    logic       prop_ready;
    logic       chk_valid = 0, viol_ack = 0;
    logic [7:0] chk_base = 0;
    logic [8:0] chk_len = 0;
    logic       chk_ready, chk_done, chk_viol;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flowtag_unit i_flowtag_unit (.*);

    task automatic expect_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_init(input [7:0] b, input [8:0] l, input bit t, output int busy_cycles);
        @(negedge clk);
        init_valid = 1; init_base = b; init_len = l; init_tag = t;
        while (!init_ready) @(negedge clk);
        @(negedge clk);
        init_valid = 0;
        busy_cycles = 0;
        while (init_busy) begin busy_cycles++; @(negedge clk); end
    endtask

    task automatic do_prop(input [2:0] op, input [3:0] rd, rs1, rs2, input [7:0] a);
        @(negedge clk);
        prop_valid = 1; prop_op = op; prop_rd = rd; prop_rs1 = rs1; prop_rs2 = rs2; prop_addr = a;
        while (!prop_ready) @(negedge clk);
        @(negedge clk);
        prop_valid = 0;
    endtask

    task automatic ack_viol();
        @(negedge clk); viol_ack = 1;
        @(negedge clk); viol_ack = 0;
    endtask

    task automatic do_check(input [7:0] b, input [8:0] l, input bit clear, output bit v, output int cyc);
        if (clear) ack_viol();
        @(negedge clk);
        chk_valid = 1; chk_base = b; chk_len = l;
        while (!chk_ready) @(negedge clk);
        @(negedge clk);
        chk_valid = 0;
        cyc = 1;
        while (!chk_done) begin @(negedge clk); cyc++; end
        v = chk_viol;
    endtask

    // Brings a register tag out by storing it to spare word 0xF0 and checking that word.
    task automatic reg_tag(input [3:0] r, output bit t);
        int c;
        do_prop(3'd4, 4'd0, r, 4'd0, 8'hF0);
        do_check(8'hF0, 9'd1, 1, t, c);
    endtask

    task automatic t_reset();
        bit v; int c;
        expect_eq("R1 init_busy", init_busy, 0);
        expect_eq("R1 chk_done", chk_done, 0);
        expect_eq("R1 chk_viol", chk_viol, 0);
        expect_eq("R1 prop_ready", prop_ready, 1);
        do_check(8'h00, 9'd256, 0, v, c);
        expect_eq("R1 all memory public", v, 0);
        reg_tag(4'd15, v);
        expect_eq("R1 register public", v, 0);
    endtask

    task automatic t_init();
        bit v; int c, bc;
        do_init(8'h10, 9'd4, 1, bc);
        expect_eq("R2 busy cycles", bc, 4);
        do_check(8'h10, 9'd4, 1, v, c);
        expect_eq("R2 region secret", v, 1);
        do_check(8'h14, 9'd1, 1, v, c);
        expect_eq("R2 word after region", v, 0);
        do_check(8'h0F, 9'd1, 1, v, c);
        expect_eq("R2 word before region", v, 0);
        do_init(8'h20, 9'd0, 1, bc);
        expect_eq("R2 zero length busy", bc, 0);
        do_check(8'h20, 9'd1, 1, v, c);
        expect_eq("R2 zero length no tag", v, 0);
    endtask

    task automatic t_wrap();
        bit v; int c, bc;
        do_init(8'hFE, 9'd4, 1, bc);
        do_check(8'h00, 9'd2, 1, v, c);
        expect_eq("R11 wrapped words secret", v, 1);
        do_check(8'h02, 9'd1, 1, v, c);
        expect_eq("R11 word past wrap", v, 0);
        do_check(8'hFD, 9'd1, 1, v, c);
        expect_eq("R11 word before base", v, 0);
        do_init(8'hFE, 9'd4, 0, bc);
        do_check(8'hFC, 9'd8, 1, v, c);
        expect_eq("R11 wrapped region cleared", v, 0);
    endtask

    task automatic t_prop();
        bit v; int c;
        do_prop(3'd3, 4'd3, 4'd0, 4'd0, 8'h11);
        reg_tag(4'd3, v); expect_eq("R7 load secret", v, 1);
        do_prop(3'd3, 4'd4, 4'd0, 4'd0, 8'h30);
        reg_tag(4'd4, v); expect_eq("R7 load public", v, 0);
        do_prop(3'd0, 4'd5, 4'd4, 4'd3, 8'h00);
        reg_tag(4'd5, v); expect_eq("R4 or with secret", v, 1);
        do_prop(3'd0, 4'd6, 4'd4, 4'd4, 8'h00);
        reg_tag(4'd6, v); expect_eq("R4 or of publics", v, 0);
        do_prop(3'd1, 4'd7, 4'd3, 4'd0, 8'h00);
        reg_tag(4'd7, v); expect_eq("R5 move secret", v, 1);
        do_prop(3'd1, 4'd3, 4'd4, 4'd0, 8'h00);
        reg_tag(4'd3, v); expect_eq("R5 move overwrites", v, 0);
        do_prop(3'd1, 4'd8, 4'd5, 4'd0, 8'h00);
        do_prop(3'd2, 4'd8, 4'd5, 4'd5, 8'h00);
        reg_tag(4'd8, v); expect_eq("R6 immediate public", v, 0);
        do_prop(3'd4, 4'd9, 4'd5, 4'd0, 8'h40);
        do_check(8'h40, 9'd1, 1, v, c);
        expect_eq("R8 store secret", v, 1);
        reg_tag(4'd9, v); expect_eq("R8 store leaves rd", v, 0);
        do_prop(3'd4, 4'd0, 4'd4, 4'd0, 8'h40);
        do_check(8'h40, 9'd1, 1, v, c);
        expect_eq("R8 store public", v, 0);
    endtask

    task automatic t_check();
        bit v; int c;
        do_check(8'h80, 9'd5, 1, v, c);
        expect_eq("R9 done latency len 5", c, 6);
        do_check(8'h10, 9'd0, 1, v, c);
        expect_eq("R9 done latency len 0", c, 1);
        expect_eq("R9 len 0 no violation", v, 0);
        @(negedge clk);
        expect_eq("R9 done single pulse", chk_done, 0);
        do_check(8'h13, 9'd1, 1, v, c);
        expect_eq("R10 violation set", v, 1);
        do_check(8'h30, 9'd2, 0, v, c);
        expect_eq("R10 sticky over clean check", v, 1);
        ack_viol();
        expect_eq("R10 ack clears", chk_viol, 0);
    endtask

    task automatic t_init_vs_prop();
        bit v; int waited = 0;
        @(negedge clk);
        init_valid = 1; init_base = 8'h60; init_len = 9'd6; init_tag = 1;
        prop_valid = 1; prop_op = 3'd3; prop_rd = 4'd10; prop_rs1 = 0; prop_rs2 = 0; prop_addr = 8'h62;
        #1;
        expect_eq("R3 stalled in same cycle", prop_ready, 0);
        @(negedge clk);
        init_valid = 0;
        while (!prop_ready) begin waited++; @(negedge clk); end
        @(negedge clk);
        prop_valid = 0;
        expect_eq("R3 stall length", waited, 6);
        reg_tag(4'd10, v);
        expect_eq("R3 load after init sees secret", v, 1);
    endtask

    task automatic t_init_vs_check();
        int c;
        ack_viol();
        @(negedge clk);
        init_valid = 1; init_base = 8'h70; init_len = 9'd5; init_tag = 1;
        chk_valid = 1; chk_base = 8'h70; chk_len = 9'd5;
        #1;
        expect_eq("R12 check deferred", chk_ready, 0);
        @(negedge clk);
        init_valid = 0;
        expect_eq("R12 init_ready low while busy", init_ready, 0);
        expect_eq("R12 chk_ready low while busy", chk_ready, 0);
        while (!chk_ready) @(negedge clk);
        @(negedge clk);
        chk_valid = 0;
        c = 1;
        while (!chk_done) begin @(negedge clk); c++; end
        expect_eq("R12 check after init finds secret", chk_viol, 1);
        expect_eq("R12 deferred check latency", c, 6);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_init();
        t_wrap();
        t_prop();
        t_check();
        t_init_vs_prop();
        t_init_vs_check();
        finish_run();
    end
endmodule